// File: doc/BRIEF.md
# Delay-line DRAM controller

This block turns one or two external nibble-wide DRAMs (64K locations of 4 bits each) into a circular delay memory for audio effects such as echo and surround. Internal effect logic presents a request made of a direction (read or write), a delay offset in samples and, for writes, a 4-bit nibble. The block converts the offset into a ring address relative to a write pointer that steps once per audio frame. It then multiplexes row and column onto a shared address bus and sequences the row strobe, the column strobe and separate read and write strobes.

Consecutive requests that fall into the row already open on the same device are served with further column cycles under one row strobe. A CAS-before-RAS refresh is inserted at a fixed interval and wins over any waiting request. Read nibbles are captured at the end of the column strobe and handed back with a one-cycle valid flag. With two devices fitted, the most significant ring-address bit chooses which device's row strobe is used.

Top module: `delay_dram_ctrl`

## Requirements
- R1: While reset is held, every row strobe, the column strobe, the read strobe and the write strobe are high (inactive), `rdata_valid` is low, and the write pointer is zero.
- R2: An accepted request addresses location (write pointer − `req_offset`) modulo 2^AW, where AW = ROW_W + COL_W (+1 when NDEV is 2). A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high.
- R3: Each cycle with `frame_tick` high advances the write pointer by one, wrapping from 2^AW−1 to 0. Without a tick the pointer holds.
- R4: The row (ring-address bits [COL_W+ROW_W−1:COL_W], on bus bits [ROW_W−1:0], upper bus bits zero) is on `dram_addr` in the cycle before a row strobe falls and stays there in the cycle it falls.
- R5: The column (ring-address bits [COL_W−1:0]) is on `dram_addr` in the cycle before the column strobe falls for an access and stays there in the cycle it falls.
- R6: With NDEV = 2, ring-address bit AW−1 equal to 1 selects `ras_n[1]` and 0 selects `ras_n[0]`. Outside refresh, at most one row strobe is low.
- R7: A write drives `wr_n` low with the nibble on `dq_out` and `dq_oe` high. A read drives `rd_n` low. The two are never low together and only while a row strobe is low.
- R8: For a read, `dq_in` is sampled at the clock edge that ends the single column-low cycle and appears on `rdata` with `rdata_valid` high for one cycle. Results come back in request order.
- R9: A request to the same device and row as the access just finished is accepted without the row strobe rising, and gets its own column strobe.
- R10: Refresh lowers the column strobe first and then all row strobes together, with read and write strobes high. A refresh starts every REF_INTERVAL cycles, delayed by at most a few cycles, and no request is accepted while one is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One pulse per audio frame; steps the write pointer |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | AW | Delay in samples behind the write pointer |
| req_wdata | input | 4 | Nibble to store |
| req_ready | output | 1 | Request can be taken this cycle |
| rdata | output | 4 | Nibble read back |
| rdata_valid | output | 1 | `rdata` holds a new result |
| dram_addr | output | BUS_W | Multiplexed row/column address |
| ras_n | output | NDEV | Row strobe per device, active low |
| cas_n | output | 1 | Column strobe shared by the devices, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dq_out | output | 4 | Write data to the memory |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | 4 | Read data from the memory |

## Verification
On every cycle the assertions check the address setup and hold around each strobe edge, the single active device outside refresh, the CAS-before-RAS order, the exclusion of read against write, the return of read data after a read column cycle, the pointer step and the persistence of a pending refresh. Only the bench's scenarios can show that data lands in the right device, row and column and comes back intact across the whole ring. They also show that the pointer wraps and that page grouping really reduces row cycles. The refresh spacing is checked under continuous traffic.

// File: rtl/dlc_pkg.sv
package dlc_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,
        S_RAS,
        S_COL,
        S_CAS,
        S_PAGE,
        S_PRE,
        S_RF_CAS,
        S_RF_RAS,
        S_RF_END
    } seq_state_e;

    typedef struct packed {
        logic             write;
        logic [NIB_W-1:0] data;
    } op_t;

    function automatic logic in_access(seq_state_e s);
        return (s == S_RAS) || (s == S_COL) || (s == S_CAS) || (s == S_PAGE);
    endfunction

    function automatic logic strobe_phase(seq_state_e s);
        return (s == S_COL) || (s == S_CAS);
    endfunction

endpackage

// File: rtl/dlc_ring_ptr.sv
module dlc_ring_ptr #(
    parameter int AW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_tick,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] ring_addr
);

    always_ff @(posedge clk) begin
        if (rst)
            wptr <= '0;
        else if (frame_tick)
            wptr <= wptr + AW'(1);
    end

    assign ring_addr = wptr - offset;

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        frame_tick |=> (wptr == $past(wptr) + AW'(1))); // R3
    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !frame_tick |=> $stable(wptr)); // R3

endmodule

// File: rtl/dlc_refresh_timer.sv
module dlc_refresh_timer #(
    parameter int INTERVAL = 390
) (
    input  logic clk,
    input  logic rst,
    input  logic ack,
    output logic due
);

    localparam int CW = (INTERVAL < 2) ? 1 : $clog2(INTERVAL);
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            due <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
            if (ack)
                due <= 1'b0;
            else if (cnt == LAST)
                due <= 1'b1;
        end
    end

    AST_DUE_PERSISTS: assert property (@(posedge clk) disable iff (rst)
        (due && !ack) |=> due); // R10

endmodule

// File: rtl/dlc_seq.sv
module dlc_seq
    import dlc_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    parameter int NDEV  = 2,
    parameter int BUS_W = 9,
    parameter int AW    = ROW_W + COL_W + ((NDEV == 2) ? 1 : 0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [NIB_W-1:0] req_wdata,
    input  logic [AW-1:0]    req_addr,
    output logic             req_ready,
    input  logic             ref_due,
    output logic             ref_ack,
    output logic [BUS_W-1:0] dram_addr,
    output logic [NDEV-1:0]  ras_n,
    output logic             cas_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [NIB_W-1:0] dq_out,
    output logic             dq_oe,
    input  logic [NIB_W-1:0] dq_in,
    output logic [NIB_W-1:0] rdata,
    output logic             rdata_valid
);

    seq_state_e state, nxt;
    op_t        cur_op;
    logic [ROW_W-1:0] cur_row, in_row;
    logic [COL_W-1:0] cur_col, in_col;
    logic             cur_bank, in_bank;
    logic             hit, accept;

    assign in_col = req_addr[COL_W-1:0];
    assign in_row = req_addr[COL_W +: ROW_W];

    generate
        if (NDEV == 2) begin : g_two_dev
            assign in_bank = req_addr[AW-1];
        end else begin : g_one_dev
            assign in_bank = 1'b0;
        end
    endgenerate

    assign hit       = (in_bank == cur_bank) && (in_row == cur_row);
    assign req_ready = !ref_due && ((state == S_IDLE) || ((state == S_PAGE) && hit));
    assign accept    = req_valid && req_ready;
    assign ref_ack   = (state == S_IDLE) && ref_due;

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (ref_due) nxt = S_RF_CAS;
                      else if (accept) nxt = S_ROW;
            S_ROW:    nxt = S_RAS;
            S_RAS:    nxt = S_COL;
            S_COL:    nxt = S_CAS;
            S_CAS:    nxt = S_PAGE;
            S_PAGE:   nxt = accept ? S_COL : S_PRE;
            S_PRE:    nxt = S_IDLE;
            S_RF_CAS: nxt = S_RF_RAS;
            S_RF_RAS: nxt = S_RF_END;
            S_RF_END: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            cur_op      <= '0;
            cur_row     <= '0;
            cur_col     <= '0;
            cur_bank    <= 1'b0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                cur_op   <= '{write: req_write, data: req_wdata};
                cur_row  <= in_row;
                cur_col  <= in_col;
                cur_bank <= in_bank;
            end
            rdata_valid <= (state == S_CAS) && !cur_op.write;
            if ((state == S_CAS) && !cur_op.write)
                rdata <= dq_in;
        end
    end

    always_comb begin
        dram_addr = '0;
        if ((state == S_ROW) || (state == S_RAS))
            dram_addr = BUS_W'(cur_row);
        else if ((state == S_COL) || (state == S_CAS) || (state == S_PAGE))
            dram_addr = BUS_W'(cur_col);
    end

    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_ras
            assign ras_n[d] = !((in_access(state) && (cur_bank == 1'(d))) || (state == S_RF_RAS));
        end
    endgenerate

    assign cas_n  = !((state == S_CAS) || (state == S_RF_CAS) || (state == S_RF_RAS));
    assign rd_n   = !(strobe_phase(state) && !cur_op.write);
    assign wr_n   = !(strobe_phase(state) && cur_op.write);
    assign dq_out = cur_op.data;
    assign dq_oe  = strobe_phase(state) && cur_op.write;

    logic any_ras_low;
    assign any_ras_low = ~&ras_n;

    AST_ROW_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($rose(any_ras_low) && cas_n) |-> $stable(dram_addr)); // R4
    AST_COL_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && any_ras_low) |-> $stable(dram_addr)); // R5
    AST_SINGLE_DEV: assert property (@(posedge clk) disable iff (rst)
        (state != S_RF_RAS) |-> ($countones(~ras_n) <= 1)); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> ((rd_n != wr_n) && any_ras_low)); // R7
    AST_READ_RETURN: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> $past(!cas_n && !rd_n)); // R8
    AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
        ($rose(any_ras_low) && !cas_n) |-> ((ras_n == '0) && rd_n && wr_n)); // R10

endmodule

// File: rtl/delay_dram_ctrl.sv
module delay_dram_ctrl
    import dlc_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int COL_W        = 8,
    parameter int NDEV         = 2,
    parameter int BUS_W        = 9,
    parameter int REF_INTERVAL = 390,
    parameter int AW           = ROW_W + COL_W + ((NDEV == 2) ? 1 : 0)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_tick,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_offset,
    input  logic [3:0]       req_wdata,
    output logic             req_ready,
    output logic [3:0]       rdata,
    output logic             rdata_valid,
    output logic [BUS_W-1:0] dram_addr,
    output logic [NDEV-1:0]  ras_n,
    output logic             cas_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [3:0]       dq_out,
    output logic             dq_oe,
    input  logic [3:0]       dq_in
);

    logic [AW-1:0] wptr, ring_addr;
    logic          ref_due, ref_ack;

    dlc_ring_ptr #(.AW(AW)) i_ring (
        .clk       (clk),
        .rst       (rst),
        .frame_tick(frame_tick),
        .offset    (req_offset),
        .wptr      (wptr),
        .ring_addr (ring_addr)
    );

    dlc_refresh_timer #(.INTERVAL(REF_INTERVAL)) i_refresh (
        .clk(clk),
        .rst(rst),
        .ack(ref_ack),
        .due(ref_due)
    );

    dlc_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .NDEV(NDEV), .BUS_W(BUS_W), .AW(AW)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .req_addr   (ring_addr),
        .req_ready  (req_ready),
        .ref_due    (ref_due),
        .ref_ack    (ref_ack),
        .dram_addr  (dram_addr),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe),
        .dq_in      (dq_in),
        .rdata      (rdata),
        .rdata_valid(rdata_valid)
    );

    AST_RESET_WPTR: assert property (@(posedge clk)
        $past(rst) |-> (wptr == '0)); // R1

endmodule

// File: tb/test_delay_dram_ctrl.sv
module test_delay_dram_ctrl;

    localparam int ROW_W = 4;
    localparam int COL_W = 4;
    localparam int NDEV  = 2;
    localparam int BUS_W = 9;
    localparam int RINT  = 40;
    localparam int AW    = ROW_W + COL_W + 1;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_tick = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [AW-1:0] req_offset = '0;
    logic [3:0] req_wdata = '0;
    logic req_ready;
    logic [3:0] rdata;
    logic rdata_valid;
    logic [BUS_W-1:0] dram_addr;
    logic [NDEV-1:0] ras_n;
    logic cas_n, rd_n, wr_n, dq_oe;
    logic [3:0] dq_out;
    logic [3:0] dq_in = '0;

    delay_dram_ctrl #(
        .ROW_W(ROW_W), .COL_W(COL_W), .NDEV(NDEV), .BUS_W(BUS_W), .REF_INTERVAL(RINT)
    ) i_delay_dram_ctrl (
        .clk(clk), .rst(rst), .frame_tick(frame_tick), .req_valid(req_valid),
        .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
        .req_ready(req_ready), .rdata(rdata), .rdata_valid(rdata_valid),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .rd_n(rd_n),
        .wr_n(wr_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pat(int a);
        return 4'((a * 7) ^ (a >> 4) ^ 3);
    endfunction

    // memory model: two devices, 16 rows x 16 columns
    logic [3:0] mem [0:1][0:15][0:15];
    logic [3:0] m_row [0:1];
    logic [1:0] p_ras = 2'b11;
    logic       p_cas = 1'b1;
    int cyc = 0;
    int ras_falls = 0;
    int refreshes = 0;
    int last_ref = -1;
    int gap_bad = 0;
    int cbr_bad = 0;
    int wr_misdrive = 0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (p_ras == 2'b11 && ras_n != 2'b11) begin
                if (cas_n) begin
                    ras_falls++;
                    for (int b = 0; b < 2; b++)
                        if (!ras_n[b]) m_row[b] = dram_addr[3:0];
                end else begin
                    refreshes++;
                    if (!(ras_n == 2'b00 && rd_n && wr_n)) cbr_bad++;
                    if (last_ref >= 0 && (cyc - last_ref > RINT + 8 || cyc - last_ref < RINT - 8))
                        gap_bad++;
                    last_ref = cyc;
                end
            end
            if (p_cas && !cas_n && ras_n != 2'b11 && ras_n != 2'b00) begin
                automatic int b = ras_n[0] ? 1 : 0;
                if (!wr_n) begin
                    if (!dq_oe) wr_misdrive++;
                    mem[b][m_row[b]][dram_addr[3:0]] = dq_out;
                end
                if (!rd_n) dq_in = mem[b][m_row[b]][dram_addr[3:0]];
            end
        end
        p_ras = ras_n;
        p_cas = cas_n;
    end

    // read result collector
    logic [3:0] exp_q [0:1023];
    int exp_wr = 0;
    int exp_rd = 0;

    always @(negedge clk) begin
        if (!rst && rdata_valid) begin
            chk(rdata == exp_q[exp_rd], "R8 R2 read data", int'(rdata), int'(exp_q[exp_rd]));
            exp_rd++;
        end
    end

    task automatic issue(bit w, int off, logic [3:0] d, int addr);
        req_valid  = 1'b1;
        req_write  = w;
        req_offset = AW'(off);
        req_wdata  = d;
        #1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        if (!w) begin
            exp_q[exp_wr] = pat(addr);
            exp_wr++;
        end
    endtask

    task automatic go_idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            frame_tick = 1'b1;
            @(negedge clk);
            frame_tick = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int falls0, refs0, mism;
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 16; r++)
                for (int c = 0; c < 16; c++) mem[b][r][c] = 4'h0;
        m_row[0] = '0;
        m_row[1] = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ras_n == 2'b11 && cas_n && rd_n && wr_n, "R1 strobes idle", int'({ras_n, cas_n, rd_n, wr_n}), 31);
        chk(!rdata_valid, "R1 rdata_valid low", int'(rdata_valid), 0);
        rst = 1'b0;
        @(negedge clk);

        // write sweep over whole ring, write pointer is zero (R1, R2)
        falls0 = ras_falls;
        refs0  = refreshes;
        for (int k = 0; k < DEPTH; k++)
            issue(1'b1, k, pat((DEPTH - k) % DEPTH), (DEPTH - k) % DEPTH);
        go_idle(8);
        // R9: page grouping; 32 rows touched, each refresh may reopen one
        chk(ras_falls - falls0 <= 33 + (refreshes - refs0), "R9 row cycles",
            ras_falls - falls0, 33 + (refreshes - refs0));
        chk(refreshes - refs0 >= 20, "R10 refresh during traffic", refreshes - refs0, 20);

        // R4 R5 R6: placement by device, row and column
        mism = 0;
        for (int a = 0; a < DEPTH; a++)
            if (mem[a >> 8][(a >> 4) & 15][a & 15] != pat(a)) mism++;
        chk(mism == 0, "R4 R5 R6 placement", mism, 0);
        chk(mem[1][0][0] == pat(256), "R6 upper device", int'(mem[1][0][0]), int'(pat(256)));
        chk(wr_misdrive == 0, "R7 write drive", wr_misdrive, 0);

        // R3: five frames, then read the whole ring back
        ticks(5);
        for (int k = 0; k < DEPTH; k++)
            issue(1'b0, k, 4'h0, (5 - k + DEPTH) % DEPTH);
        go_idle(10);
        chk(exp_rd == DEPTH, "R8 result count", exp_rd, DEPTH);

        // R3: write at offset zero lands at pointer 5
        issue(1'b1, 0, 4'hA, 5);
        go_idle(8);
        chk(mem[0][0][5] == 4'hA, "R3 pointer after ticks", int'(mem[0][0][5]), 10);

        // R3 R2: wrap to zero, offset 3 lands at 509
        ticks(DEPTH - 5);
        issue(1'b1, 3, 4'h6, 509);
        go_idle(8);
        chk(mem[1][15][13] == 4'h6, "R3 R2 wrap", int'(mem[1][15][13]), 6);
        issue(1'b0, 3, 4'h0, 509);
        exp_q[exp_wr - 1] = 4'h6;
        go_idle(8);
        chk(exp_rd == exp_wr, "R8 wrap read", exp_rd, exp_wr);

        // R10: refresh shape and spacing
        go_idle(3 * RINT);
        chk(cbr_bad == 0, "R10 refresh order", cbr_bad, 0);
        chk(gap_bad == 0, "R10 refresh spacing", gap_bad, 0);
        chk(refreshes > 0, "R10 refresh seen", refreshes, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule